// File: doc/BRIEF.md
# Serially Configured Signal Crosspoint

This block steers a 20-signal input bus onto a 20-signal output bus through one multiplexer per output. Each output's selection lives in a configuration register. The block does not take that register from logic parameters. Instead, a small sequencer fetches it over SPI from an external serial flash as soon as reset is released. Changing how the bus is interpreted therefore only needs a rewrite of the flash image. The logic itself is never rebuilt.

After reset the sequencer drops chip select and sends a read command with a start address. It then clocks in the configuration bits and raises chip select again. Only then does it flag the configuration as complete and open the output bus. Until that point every output is held low. The path is strictly one-way: each output copies one chosen input, and nothing flows back. The configuration is fetched once per reset, and the flash line is ignored afterwards.

Top module: `xpt_router`

## Requirements
- R1: While reset is asserted, chip select is high, SCLK is low, config_done is low and every output is 0.
- R2: After reset the block drives chip select low and sends 32 header bits on MOSI, MSB first: the command byte 0x03 followed by the 24-bit address 0x000000. MOSI only changes while SCLK is low, and SCLK pulses only while chip select is low.
- R3: Each SCLK period lasts CLKDIV system clocks (default 4), with rising edges exactly CLKDIV clocks apart.
- R4: After the header, 100 configuration bits are sampled from MISO on the rising edges of SCLK. In the 100-bit word the last bit received is bit 0 and the first is bit 99. The select for output i is bits [5i+4:5i] of that word, so the first bit received is the MSB of output 19's select.
- R5: After the last configuration bit the block raises chip select and asserts config_done. A complete load uses exactly 132 SCLK pulses.
- R6: While config_done is low, every output is 0 whatever the input bus carries.
- R7: Once config_done is high, output i equals input sel_i whenever sel_i is below 20. The path is combinational.
- R8: A select value of 20 to 31 drives its output low.
- R9: After config_done, MISO is ignored, SCLK stays low, chip select stays high and config_done stays high until the next reset. The routing does not change.
- R10: Each new reset fetches the configuration again, and the routing follows the new flash contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | output | 1 | Serial clock to the flash, idle low |
| spi_mosi | output | 1 | Command and address bits to the flash |
| spi_miso | input | 1 | Configuration data from the flash |
| spi_cs_n | output | 1 | Flash chip select, active low |
| sig_in | input | 20 | Input signal bus |
| sig_out | output | 20 | Routed output bus |
| config_done | output | 1 | High once the configuration is loaded and routing is live |

## Verification
The assertions assume that reset is held for at least one clock edge. They also assume that spi_miso is a synchronous signal that the flash changes only on falling SCLK edges. The bench's flash model satisfies this by driving MISO only on falling SCLK edges while chip select is low. After the load it changes MISO only on clock edges. The sig_in bus is treated as a combinational pass-through. The bench drives it away from clock edges and samples the outputs after it settles.

// File: rtl/xpt_router.sv
module xpt_router #(
  parameter int          NSIG    = 20,
  parameter int          SELW    = 5,
  parameter int          CLKDIV  = 4,
  parameter logic [7:0]  RD_CMD  = 8'h03,
  parameter logic [23:0] RD_ADDR = 24'h000000
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic            spi_sclk,
  output logic            spi_mosi,
  input  logic            spi_miso,
  output logic            spi_cs_n,
  input  logic [NSIG-1:0] sig_in,
  output logic [NSIG-1:0] sig_out,
  output logic            config_done
);
  localparam int HDR_BITS = 32;
  localparam int CFG_BITS = NSIG * SELW;
  localparam int TOTAL    = HDR_BITS + CFG_BITS;
  localparam int CNTW     = $clog2(TOTAL);
  localparam int HALF     = CLKDIV / 2;
  localparam int DIVW     = $clog2(CLKDIV);
  localparam logic [SELW-1:0] NSIG_V = SELW'(NSIG);

  typedef enum logic [1:0] {S_START, S_XFER, S_DONE} st_t;

  st_t                 st;
  logic [DIVW-1:0]     div;
  logic [CNTW-1:0]     bitn;
  logic [HDR_BITS-1:0] hdr;
  logic [CFG_BITS-1:0] cfg;
  logic                sclk_q, cs_q;

  assign spi_sclk    = sclk_q;
  assign spi_cs_n    = cs_q;
  assign spi_mosi    = hdr[HDR_BITS-1];
  assign config_done = (st == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_START;
      div    <= '0;
      bitn   <= '0;
      hdr    <= {RD_CMD, RD_ADDR};
      cfg    <= '0;
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      case (st)
        S_START: begin
          cs_q <= 1'b0;
          st   <= S_XFER;
        end
        S_XFER: begin
          if (div == DIVW'(CLKDIV-1)) div <= '0;
          else                        div <= div + 1'b1;
          if (div == DIVW'(HALF-1)) begin
            sclk_q <= 1'b1;
            if (bitn >= CNTW'(HDR_BITS)) cfg <= {cfg[CFG_BITS-2:0], spi_miso};
          end
          if (div == DIVW'(CLKDIV-1)) begin
            sclk_q <= 1'b0;
            hdr    <= {hdr[HDR_BITS-2:0], 1'b0};
            if (bitn == CNTW'(TOTAL-1)) begin
              st   <= S_DONE;
              cs_q <= 1'b1;
            end else begin
              bitn <= bitn + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < NSIG; i++) begin : g_out
    logic [SELW-1:0] sel;
    assign sel        = cfg[i*SELW +: SELW];
    assign sig_out[i] = config_done && (sel < NSIG_V) && sig_in[sel];
  end

  AST_SCLK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> !spi_cs_n); // R2
  AST_MOSI_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> $stable(spi_mosi)); // R2
  AST_DONE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    config_done |-> (spi_cs_n && !spi_sclk)); // R5
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    config_done |=> config_done); // R9
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    config_done |=> $stable(cfg)); // R9
endmodule

// File: tb/sim_xpt_router.sv
module sim_xpt_router;
  localparam int  CLK_PERIOD = 10;
  localparam int  NS = 20;
  localparam int  DIV = 4;
  localparam int  NBITS = NS * 5;

  logic clk = 0, rst_n = 0, miso = 0;
  logic sclk, mosi, cs_n, done;
  logic [NS-1:0] sin = '0, sout;

  int passed = 0, total = 0;
  logic [4:0] sel_tab [NS];
  logic [NBITS-1:0] image;
  logic [31:0] hdr_cap;
  int nrise, nrise_all, bad_period;
  time last_rise;

  always #(CLK_PERIOD/2) clk = ~clk;

  xpt_router #(.NSIG(NS), .SELW(5), .CLKDIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_mosi(mosi), .spi_miso(miso),
    .spi_cs_n(cs_n), .sig_in(sin), .sig_out(sout), .config_done(done));

  always @(posedge sclk) begin
    nrise_all = nrise_all + 1;
    if (!cs_n) begin
      if (nrise < 32) hdr_cap = {hdr_cap[30:0], mosi};
      nrise = nrise + 1;
    end
    if (last_rise != 0 && nrise <= 132 && ($time - last_rise) != DIV*CLK_PERIOD)
      bad_period = bad_period + 1;
    last_rise = $time;
  end

  always @(negedge sclk)
    if (!cs_n && nrise >= 32 && nrise < 32 + NBITS)
      miso <= image[NBITS-1-(nrise-32)];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (ok) passed++;
    else $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
  endtask

  function automatic logic [NS-1:0] model(input logic [NS-1:0] v);
    logic [NS-1:0] r = '0;
    for (int i = 0; i < NS; i++) r[i] = (sel_tab[i] < 5'd20) ? v[sel_tab[i]] : 1'b0;
    return r;
  endfunction

  task automatic load_and_check(input string name);
    for (int i = 0; i < NS; i++) image[i*5 +: 5] = sel_tab[i];
    @(negedge clk);
    rst_n = 0; nrise = 0; nrise_all = 0; bad_period = 0; last_rise = 0; hdr_cap = '0; miso = 0;
    sin = 20'hFFFFF;
    repeat (4) @(negedge clk);
    #1;
    chk(cs_n === 1'b1 && sclk === 1'b0 && done === 1'b0, {"R1 idle pins ", name}, {cs_n, sclk, done}, 3'b100);
    chk(sout === '0, {"R1 outputs in reset ", name}, sout, 0);
    rst_n = 1;
    for (int c = 0; c < 2000 && !done; c++) begin
      @(negedge clk);
      sin = {$urandom} & 20'hFFFFF;
      #1;
      if (c == 50 || c == 300) chk(sout === '0, "R6 outputs held low while loading", sout, 0);
    end
    chk(done === 1'b1, {"R5 config_done ", name}, done, 1);
    chk(cs_n === 1'b1, "R5 chip select released", cs_n, 1);
    chk(nrise == 32 + NBITS, "R5 SCLK pulse count", nrise, 32 + NBITS);
    chk(hdr_cap == 32'h03000000, "R2 read header", hdr_cap, 32'h03000000);
    chk(bad_period == 0, "R3 SCLK period", bad_period, 0);
  endtask

  task automatic route_check(input string tag);
    logic [NS-1:0] pats [4] = '{20'h00000, 20'hFFFFF, 20'h55555, 20'hAAAAA};
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); sin = pats[k]; #1;
      chk(sout === model(pats[k]), {tag, " pattern"}, sout, model(pats[k]));
    end
    for (int b = 0; b < NS; b++) begin
      #2; sin = 20'(1) << b; #1;
      chk(sout === model(sin), {tag, " walking one"}, sout, model(sin));
    end
  endtask

  task automatic ignore_miso_check;
    logic [NS-1:0] ref_out;
    @(negedge clk); sin = 20'h5A3C9; #1;
    ref_out = model(sin);
    for (int c = 0; c < 60; c++) begin
      @(posedge clk); miso <= ~miso ^ $urandom_range(0, 1);
    end
    @(negedge clk); #1;
    chk(sout === ref_out, "R9 routing unchanged after MISO activity", sout, ref_out);
    chk(done === 1'b1 && cs_n === 1'b1, "R9 done and deselected", {done, cs_n}, 2'b11);
    chk(nrise_all == 32 + NBITS, "R9 no SCLK after load", nrise_all, 32 + NBITS);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end

  initial begin
    for (int i = 0; i < NS; i++) sel_tab[i] = 5'(19 - i);
    load_and_check("reversed map");
    route_check("R4 R7 reversed map");
    ignore_miso_check();
    for (int i = 0; i < NS; i++)
      if (i % 4 == 3)      sel_tab[i] = (i < 10) ? 5'd20 : 5'd31;
      else if (i % 4 == 0) sel_tab[i] = 5'd0;
      else                 sel_tab[i] = 5'((i * 7) % 20);
    load_and_check("mixed map");
    route_check("R8 R10 mixed map");
    @(negedge clk); sin = 20'hFFFFF; #1;
    chk((sout & 20'h88888) == 0, "R8 out-of-range selects low", sout & 20'h88888, 0);
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end
endmodule